// File: doc/BRIEF.md
# Raster-Timed Interrupt Burst Scheduler

This block raises a run of interrupts that line up with positions on the video raster, for example a per-line interrupt that follows a light-pen or beam position. It watches a free-running cycle counter supplied from outside and a one-cycle frame-start pulse, and it latches the counter value at the most recent frame start as its time reference. A request carries a video standard (60 Hz with 263 lines, or 50 Hz with 314 lines), a target line, a horizontal cycle offset and a repeat count.

On a request the block works out the first event time. That time is one full frame after the reference, plus the target line's share of a frame, plus the horizontal offset. The line's share is found with a serial divider. Once that event has fired, the block re-arms itself one line period after the previous *scheduled* time. It does this until the repeat count is used up. Every event sets the line-interrupt flag in a status register, and software clears that flag by writing a zero to it. The interrupt output follows the status flags through a mask register.

A state machine sequences the work. Its states are `ST_IDLE` (nothing armed), `ST_DIV` (divider running), `ST_ARM` (first offset being loaded) and `ST_WAIT` (comparing the counter against the armed offset). Its transitions are:
- T_REQ: any state to `ST_DIV` when a request arrives.
- T_QUOT: `ST_DIV` to `ST_ARM` when the quotient is ready.
- T_LOAD: `ST_ARM` to `ST_WAIT`.
- T_REARM: `ST_WAIT` to `ST_WAIT` when an event fires and more remain.
- T_DONE: `ST_WAIT` to `ST_IDLE` when the last event fires.

Top module: `raster_irq_sched`

## Requirements
- R1: After reset, `status`, `mask`, `irq` and `busy` are all zero.
- R2: The frame length F is CLK_HZ/60 when `req_std`=0 and CLK_HZ/50 when `req_std`=1. The line count N is 263 when `req_std`=0 and 314 when `req_std`=1. The first event time is ref + F + (line*F)/N + hoff, where all divisions are integer divisions and ref is the reference cycle.
- R3: An event fires at the clock edge where `cycle_cnt` equals the event time. Bit 10 of `status` reads 1 from that edge onward.
- R4: Each later event is due at the previous scheduled time plus L, where L = F/N (integer). A request produces max(count,1) events in total.
- R5: A request with count 0 produces exactly one event. After the last event, `busy` drops and no further event fires.
- R6: A request replaces any burst in progress and reloads the count. A request in the same cycle as a due event cancels that event.
- R7: Event times are held as unsigned 32-bit offsets from the reference and compared with wrap-around subtraction. A burst whose times cross the counter wrap fires on time.
- R8: `irq` is 1 exactly when some bit is set in both `status` and `mask`. Only bit 10 of `status` can ever be set.
- R9: A `st_wr` write clears every `status` bit that is written as 0 and leaves the bits written as 1 unchanged. An event firing in the same cycle as the write wins, and bit 10 stays set.
- R10: The reference is the `cycle_cnt` value at the latest `frame_start` pulse at or before the request. Frame pulses after the request do not move the armed burst.
- R11: `busy` is 1 from the cycle after a request until the last event of the burst has fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_cnt | input | CYC_W | Free-running cycle counter |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| req_valid | input | 1 | Request strobe |
| req_std | input | 1 | Video standard: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 314 lines |
| req_count | input | CNT_W | Number of events in the burst (0 acts as 1) |
| req_hoff | input | HOFF_W | Horizontal offset in cycles |
| req_line | input | LINE_W | Target line |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | STAT_W | Status write data; a 0 bit clears that flag |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | STAT_W | Mask write data |
| status | output | STAT_W | Interrupt status flags |
| mask | output | STAT_W | Interrupt mask |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | A burst is armed or being prepared |

## Verification
The bench builds the block with its default parameters. These are a 33,868,800 Hz clock, a 32-bit counter and status bit 10. With these values the line periods of the two standards differ (2146 and 2157 cycles), so a wrong standard selection shows up in the event times.

The bench drives the cycle counter itself. It jumps the counter to a few cycles before each predicted event and then steps it one at a time. This makes every event exact to the cycle, even though a frame lasts more than half a million cycles. The same control lets it place the frame reference just below the 32-bit wrap point.

// File: rtl/ris_pkg.sv
package ris_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_ARM,
        ST_WAIT
    } ris_state_e;

    localparam int unsigned RATE_A  = 60;
    localparam int unsigned LINES_A = 263;
    localparam int unsigned RATE_B  = 50;
    localparam int unsigned LINES_B = 314;

endpackage

// File: rtl/ris_serdiv.sv
module ris_serdiv #(
    parameter int NW = 41,
    parameter int DW = 9,
    parameter int QW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [QW-1:0] quotient
);
    localparam int CW = $clog2(NW + 1);

    logic          run_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] div_q;
    logic [NW-1:0] quo_q;
    logic [DW:0]   trial;
    logic          ge;

    // restoring step: shift in next dividend bit, subtract if it fits
    assign trial = {rem_q, quo_q[NW-1]};
    assign ge    = trial >= {1'b0, div_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            div_q  <= '0;
            quo_q  <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            done_q <= 1'b0;
            cnt_q  <= '0;
            rem_q  <= '0;
            div_q  <= divisor;
            quo_q  <= dividend;
        end else if (run_q) begin
            rem_q  <= ge ? DW'(trial - {1'b0, div_q}) : DW'(trial);
            quo_q  <= {quo_q[NW-2:0], ge};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CW'(NW - 1)) begin
                run_q  <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done     = done_q;
    assign quotient = quo_q[QW-1:0];

endmodule

// File: rtl/ris_status_regs.sv
module ris_status_regs #(
    parameter int STAT_W  = 16,
    parameter int IRQ_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    logic [STAT_W-1:0] flag_q, flag_d;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    always_comb begin
        set_vec = STAT_W'(fire) << IRQ_BIT;
        clr_vec = st_wr ? ~st_wdata : '0;
        // a same-cycle event overrides the acknowledge
        flag_d  = set_vec | (flag_q & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    assign status = flag_q;
    assign mask   = mask_q;
    assign irq    = |(flag_q & mask_q);

endmodule

// File: rtl/raster_irq_sched.sv
module raster_irq_sched
    import ris_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 33868800,
    parameter int          CYC_W   = 32,
    parameter int          LINE_W  = 9,
    parameter int          HOFF_W  = 16,
    parameter int          CNT_W   = 8,
    parameter int          STAT_W  = 16,
    parameter int          IRQ_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CYC_W-1:0]  cycle_cnt,
    input  logic              frame_start,
    input  logic              req_valid,
    input  logic              req_std,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [HOFF_W-1:0] req_hoff,
    input  logic [LINE_W-1:0] req_line,
    input  logic              st_wr,
    input  logic [STAT_W-1:0] st_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] mask,
    output logic              irq,
    output logic              busy
);
    localparam int PROD_W = CYC_W + LINE_W;
    localparam int DIV_W  = $clog2(LINES_B + 1);

    localparam logic [CYC_W-1:0] FRAME_A = CYC_W'(CLK_HZ / RATE_A);
    localparam logic [CYC_W-1:0] FRAME_B = CYC_W'(CLK_HZ / RATE_B);
    localparam logic [CYC_W-1:0] LINE_A  = CYC_W'(CLK_HZ / RATE_A / LINES_A);
    localparam logic [CYC_W-1:0] LINE_B  = CYC_W'(CLK_HZ / RATE_B / LINES_B);

    ris_state_e state_q, state_d;

    logic              std_q;
    logic [HOFF_W-1:0] hoff_q;
    logic [CNT_W-1:0]  rem_q;
    logic [CYC_W-1:0]  frame_ref_q;
    logic [CYC_W-1:0]  ref_q;
    logic [CYC_W-1:0]  rel_q;

    logic [CYC_W-1:0]  frame_req;
    logic [CYC_W-1:0]  frame_cur;
    logic [CYC_W-1:0]  line_cur;
    logic [PROD_W-1:0] dividend;
    logic [DIV_W-1:0]  divisor;
    logic              div_done;
    logic [CYC_W-1:0]  quotient;
    logic [CYC_W-1:0]  elapsed;
    logic              fire;
    logic              last_evt;

    // per-standard constants for the incoming request and the armed burst
    assign frame_req = req_std ? FRAME_B : FRAME_A;
    assign divisor   = req_std ? DIV_W'(LINES_B) : DIV_W'(LINES_A);
    assign dividend  = PROD_W'(req_line) * PROD_W'(frame_req);
    assign frame_cur = std_q ? FRAME_B : FRAME_A;
    assign line_cur  = std_q ? LINE_B : LINE_A;

    ris_serdiv #(
        .NW (PROD_W),
        .DW (DIV_W),
        .QW (CYC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_valid),
        .dividend (dividend),
        .divisor  (divisor),
        .done     (div_done),
        .quotient (quotient)
    );

    // wrap-safe: offset from reference compared against armed offset
    assign elapsed  = cycle_cnt - ref_q;
    assign fire     = (state_q == ST_WAIT) && !req_valid && (elapsed >= rel_q);
    assign last_evt = (rem_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_DIV;
            ST_DIV: begin
                if (req_valid)     state_d = ST_DIV;
                else if (div_done) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (req_valid) state_d = ST_DIV;
                else           state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (req_valid)           state_d = ST_DIV;
                else if (fire && last_evt) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // frame reference tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           frame_ref_q <= '0;
        else if (frame_start) frame_ref_q <= cycle_cnt;
    end

    // burst datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            std_q  <= 1'b0;
            hoff_q <= '0;
            rem_q  <= '0;
            ref_q  <= '0;
            rel_q  <= '0;
        end else if (req_valid) begin
            std_q  <= req_std;
            hoff_q <= req_hoff;
            rem_q  <= (req_count == '0) ? CNT_W'(1) : req_count;
            ref_q  <= frame_start ? cycle_cnt : frame_ref_q;
        end else begin
            unique case (state_q)
                ST_ARM:  rel_q <= frame_cur + quotient + CYC_W'(hoff_q);
                ST_WAIT: begin
                    if (fire) begin
                        rem_q <= rem_q - 1'b1;
                        if (!last_evt) rel_q <= rel_q + line_cur;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
    end

    ris_status_regs #(
        .STAT_W  (STAT_W),
        .IRQ_BIT (IRQ_BIT)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .st_wr      (st_wr),
        .st_wdata   (st_wdata),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .status     (status),
        .mask       (mask),
        .irq        (irq)
    );

endmodule

// File: rtl/ris_checker.sv
module ris_checker #(
    parameter int CYC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             fire,
    input logic             last_evt,
    input logic             busy,
    input logic             irq,
    input logic             status_bit,
    input logic             mask_bit,
    input logic             st_wr,
    input logic             st_wbit,
    input logic [CYC_W-1:0] rel_q,
    input logic [CYC_W-1:0] line_cur
);
    p_fire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> status_bit);

    p_rearm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last_evt) |=> (rel_q == $past(rel_q) + $past(line_cur)));

    p_last_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && last_evt) |=> !busy);

    p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> busy);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_bit && mask_bit));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !st_wbit && !fire) |=> !status_bit);

endmodule

bind raster_irq_sched ris_checker #(.CYC_W(CYC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .fire       (fire),
    .last_evt   (last_evt),
    .busy       (busy),
    .irq        (irq),
    .status_bit (status[IRQ_BIT]),
    .mask_bit   (mask[IRQ_BIT]),
    .st_wr      (st_wr),
    .st_wbit    (st_wdata[IRQ_BIT]),
    .rel_q      (rel_q),
    .line_cur   (line_cur)
);

// File: tb/raster_irq_sched_test.sv
module raster_irq_sched_test;
    localparam int unsigned CLK_HZ = 33868800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cyc = '0;
    logic        frame_start = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_std = 1'b0;
    logic [7:0]  req_count = '0;
    logic [15:0] req_hoff = '0;
    logic [8:0]  req_line = '0;
    logic        st_wr = 1'b0;
    logic [15:0] st_wdata = '0;
    logic        mask_wr = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic [15:0] status;
    logic [15:0] mask;
    logic        irq;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] fr;

    always #4 clk = ~clk;

    raster_irq_sched uut (
        .clk(clk), .rst_n(rst_n), .cycle_cnt(cyc), .frame_start(frame_start),
        .req_valid(req_valid), .req_std(req_std), .req_count(req_count),
        .req_hoff(req_hoff), .req_line(req_line), .st_wr(st_wr),
        .st_wdata(st_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .status(status), .mask(mask), .irq(irq), .busy(busy)
    );

    function automatic logic [31:0] first_target(logic [31:0] r, logic s,
                                                 int unsigned ln, int unsigned ho);
        longint unsigned f = s ? CLK_HZ / 50 : CLK_HZ / 60;
        longint unsigned n = s ? 314 : 263;
        longint unsigned t = longint'(r) + f + (longint'(ln) * f) / n + ho;
        return t[31:0];
    endfunction

    function automatic logic [31:0] line_gap(logic s);
        return s ? (CLK_HZ / 50 / 314) : (CLK_HZ / 60 / 263);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc = cyc + 1;
        end
    endtask

    task automatic frame_pulse(logic [31:0] at);
        @(negedge clk);
        cyc = at;
        frame_start = 1'b1;
        fr = at;
        @(negedge clk);
        frame_start = 1'b0;
        cyc = cyc + 1;
    endtask

    task automatic request(logic s, int unsigned ln, int unsigned ho, int unsigned cnt);
        @(negedge clk);
        req_std = s; req_line = 9'(ln); req_hoff = 16'(ho); req_count = 8'(cnt);
        req_valid = 1'b1;
        cyc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = cyc + 1;
        step(50);
    endtask

    task automatic ack();
        @(negedge clk);
        st_wr = 1'b1; st_wdata = 16'h0000;
        cyc = cyc + 1;
        @(negedge clk);
        st_wr = 1'b0;
        cyc = cyc + 1;
    endtask

    // jump near the predicted time, step singly, report the edge of the rise
    task automatic expect_fire(logic [31:0] tgt, string tag);
        logic [31:0] seen;
        bit got;
        got = 1'b0;
        seen = '0;
        @(negedge clk);
        cyc = tgt - 32'd6;
        for (int i = 0; i < 30 && !got; i++) begin
            @(negedge clk);
            if (status[10]) begin
                got = 1'b1;
                seen = cyc;
            end else begin
                cyc = cyc + 1;
            end
        end
        check(got && seen == tgt, tag, seen, tgt);
    endtask

    task automatic expect_quiet(logic [31:0] tgt, string tag);
        @(negedge clk);
        cyc = tgt - 32'd3;
        step(8);
        check(status[10] == 1'b0 && busy == 1'b0, tag, {busy, status[10]}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] t;
        void'($urandom(32'd1234));
        step(3);
        check(status == 0 && mask == 0 && irq == 0 && busy == 0, "R1 reset",
              {status, mask[14:0], irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step(2);

        // R2/R3/R8/R9: single event, 60 Hz, with mask and write-one keep
        frame_pulse(32'h0001_0000);
        request(1'b0, 100, 37, 1);
        check(busy == 1'b1, "R11 busy after request", {31'd0, busy}, 32'h1);
        t = first_target(fr, 1'b0, 100, 37);
        expect_fire(t, "R2 R3 first event 60Hz");
        check(irq == 1'b0, "R8 masked irq low", {31'd0, irq}, 32'h0);
        @(negedge clk);
        mask_wr = 1'b1; mask_wdata = 16'h0400; cyc = cyc + 1;
        @(negedge clk);
        mask_wr = 1'b0; cyc = cyc + 1;
        check(irq == 1'b1 && mask == 16'h0400, "R8 unmasked irq high", {31'd0, irq}, 32'h1);
        @(negedge clk);
        st_wr = 1'b1; st_wdata = 16'h0400; cyc = cyc + 1;
        @(negedge clk);
        st_wr = 1'b0; cyc = cyc + 1;
        check(status == 16'h0400, "R9 write one keeps", {16'd0, status}, 32'h400);
        ack();
        check(status == 16'h0000 && irq == 1'b0, "R9 write zero clears", {16'd0, status}, 32'h0);
        check(busy == 1'b0, "R11 idle after single", {31'd0, busy}, 32'h0);

        // R4/R10: 50 Hz burst of 3, extra frame pulse after request
        frame_pulse(32'h2000_0000);
        request(1'b1, 313, 500, 3);
        frame_pulse(cyc + 32'd100);
        t = first_target(32'h2000_0000, 1'b1, 313, 500);
        for (int k = 0; k < 3; k++) begin
            expect_fire(t, (k == 0) ? "R10 ref held" : "R4 rearm 50Hz");
            ack();
            t = t + line_gap(1'b1);
        end
        expect_quiet(t, "R5 no extra after burst");

        // R7: reference just below wrap, burst of 2
        frame_pulse(32'hFFF8_0000);
        request(1'b0, 5, 1000, 2);
        t = first_target(32'hFFF8_0000, 1'b0, 5, 1000);
        expect_fire(t, "R7 wrap first");
        ack();
        expect_fire(t + line_gap(1'b0), "R7 wrap second");
        ack();

        // R6: replace running burst of 5 after its first event
        frame_pulse(32'h4000_0000);
        request(1'b0, 10, 0, 5);
        t = first_target(32'h4000_0000, 1'b0, 10, 0);
        expect_fire(t, "R6 old burst first");
        ack();
        frame_pulse(cyc + 32'd10);
        request(1'b1, 20, 9, 2);
        t = first_target(fr, 1'b1, 20, 9);
        expect_fire(t, "R6 new burst first");
        ack();
        expect_fire(t + line_gap(1'b1), "R6 new burst count");
        ack();
        expect_quiet(t + 2 * line_gap(1'b1), "R6 reload no leftover");

        // R5: count zero gives one event
        frame_pulse(32'h5555_0000);
        request(1'b1, 0, 0, 0);
        t = first_target(fr, 1'b1, 0, 0);
        expect_fire(t, "R5 count zero fires");
        ack();
        expect_quiet(t + line_gap(1'b1), "R5 count zero single");

        // random bursts
        for (int it = 0; it < 8; it++) begin
            logic s;
            int unsigned ln, ho, cnt, nev;
            s   = 1'($urandom);
            ln  = $urandom_range(0, 313);
            ho  = $urandom_range(0, 3000);
            cnt = $urandom_range(0, 3);
            nev = (cnt == 0) ? 1 : cnt;
            frame_pulse($urandom);
            request(s, ln, ho, cnt);
            t = first_target(fr, s, ln, ho);
            for (int k = 0; k < int'(nev); k++) begin
                expect_fire(t, "R2 R4 random burst");
                ack();
                t = t + line_gap(s);
            end
            expect_quiet(t, "R5 random burst end");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule